// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Device Model

This block is a synthesizable model of a small serial EEPROM that stores 16-bit words. A host drives a chip-select line, a serial clock and a serial data input, and reads results back on one serial data output. The model runs on its own system clock, finds each rising edge of the serial clock, and decodes one command frame per chip-select window. A frame is a start bit, a two-bit opcode, an address sent most significant bit first, and sixteen data bits when the command carries data.

The model reads words, writes or erases single words, fills or erases the whole array, and sets or clears a write-enable latch that gates every programming command. After a programming command it is busy for a set number of system clocks. During that time it ignores the serial port and reports its state on the data output. It is meant as a stand-in for the real part in system simulation and emulation, where host firmware needs a device that answers bit for bit.

Top module: `mw_eeprom`

## Requirements
- R1: After reset, the data output is 1, the write-enable latch is clear, and every word reads 16'hFFFF.
- R2: While chip select is high and no frame has started, serial clock rises that sample a 0 are skipped. The first sampled 1 is the start bit.
- R3: Opcode 2'b10 reads a word. The rise that samples the last address bit drives a 0 on the output. The next 16 rises each launch one data bit, most significant first. Any rise after the least significant bit drives 1.
- R4: Opcode 2'b01 followed by 16 data bits (most significant first) stores the data at the address when writing is enabled.
- R5: A programming command given while the write-enable latch is clear changes no word and starts no busy period.
- R6: Opcode 2'b11 sets only the addressed word to 16'hFFFF when writing is enabled.
- R7: Opcode 2'b00 with top address bits 2'b10 sets every word to 16'hFFFF. With top address bits 2'b01 followed by 16 data bits, it writes that data to every word. Both require writing to be enabled.
- R8: Opcode 2'b00 with top address bits 2'b11 sets the write-enable latch. With top address bits 2'b00 it clears the latch, and later programming then has no effect.
- R9: An accepted programming command makes the device busy for exactly BUSY_CYCLES system clocks, starting at the rise that completes the frame. While busy, the output is 0 one clock after chip select is high, the serial port is ignored, and the output returns to 1 when the busy period ends.
- R10: Lowering chip select outside a busy period drops any partly shifted command, returns to waiting for a start bit, and drives the output to 1 on the next clock.
- R11: The address is ADDR_W bits wide (6 or 8), sent most significant bit first. For opcode 2'b00 only the top two address bits select the subcommand, and the remaining address bits are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the serial lines |
| rst_n | input | 1 | Active-low reset |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock from the host |
| di | input | 1 | Serial data from the host |
| dout | output | 1 | Serial data and ready/busy status to the host |

## Verification
The checks assume that cs, sk and di are synchronous to clk. They also assume each sk level lasts at least one clk, so one host clock rise is seen as exactly one sampling event, and that di is steady on the cycle where that rise is detected. The stimulus changes all three lines only on falling edges of clk and holds each sk level for two clocks, so every rise is detected once with di settled. Busy-period timing is checked against cs as it is registered, so that checking does not depend on how cs moves during a programming cycle.

// File: rtl/mw_eeprom_pkg.sv
package mw_eeprom_pkg;

    localparam int unsigned WORD_W = 16;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_OPC   = 3'd1,
        ST_ADDR  = 3'd2,
        ST_DATA  = 3'd3,
        ST_RDOUT = 3'd4,
        ST_HOLD  = 3'd5,
        ST_BUSY  = 3'd6
    } st_e;

    typedef enum logic [1:0] {
        OP_EXT   = 2'b00,
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10,
        OP_ERASE = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        SUB_WDIS  = 2'b00,
        SUB_WRALL = 2'b01,
        SUB_ERALL = 2'b10,
        SUB_WEN   = 2'b11
    } sub_e;

endpackage

// File: rtl/mw_eeprom_sk_edge.sv
module mw_eeprom_sk_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sk,
    output logic sk_rise
);

    logic sk_d, sk_q;

    always_comb begin
        sk_d = sk;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sk_q <= 1'b1;   // no false rise if sk is high when reset is released
        end else begin
            sk_q <= sk_d;
        end
    end

    assign sk_rise = sk & ~sk_q;

endmodule

// File: rtl/mw_eeprom_store.sv
module mw_eeprom_store #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_all,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] word_q [DEPTH];
    logic [DATA_W-1:0] word_d [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        always_comb begin
            word_d[g] = word_q[g];
            if (wr_all || (wr_en && (wr_addr == ADDR_W'(g)))) begin
                word_d[g] = wr_data;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q[g] <= '1;   // erased state
            end else begin
                word_q[g] <= word_d[g];
            end
        end
    end

    assign rd_data = word_q[rd_addr];

endmodule

// File: rtl/mw_eeprom_ctrl.sv
module mw_eeprom_ctrl
    import mw_eeprom_pkg::*;
#(
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned BUSY_CYCLES = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              sk_rise,
    input  logic              di,
    input  logic [WORD_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_en,
    output logic              wr_all,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [WORD_W-1:0] wr_data,
    output logic              dout,
    output logic              busy,
    output logic              wel,
    output logic              rd_start
);

    localparam int unsigned BW = (BUSY_CYCLES > 1) ? $clog2(BUSY_CYCLES) : 1;
    localparam int unsigned CW = $clog2(WORD_W) + 1;
    localparam logic [CW-1:0] ADDR_LAST = CW'(ADDR_W - 1);
    localparam logic [CW-1:0] WORD_LAST = CW'(WORD_W - 1);
    localparam logic [BW-1:0] BUSY_LOAD = BW'(BUSY_CYCLES - 1);

    typedef struct packed {
        st_e               st;
        logic [CW-1:0]     cnt;
        logic [1:0]        opc;
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] sh;
        logic              wel;
        logic [BW-1:0]     bcnt;
        logic              dout;
    } ctl_t;

    ctl_t q, d;

    logic [ADDR_W-1:0] addr_full;
    logic [WORD_W-1:0] data_full;
    logic [1:0]        sub;
    logic              prog_req;
    logic              prog_all;
    logic [ADDR_W-1:0] prog_addr;
    logic [WORD_W-1:0] prog_data;

    always_comb begin
        addr_full = {q.addr[ADDR_W-2:0], di};
        data_full = {q.sh[WORD_W-2:0], di};
        sub       = addr_full[ADDR_W-1 -: 2];
        d         = q;
        prog_req  = 1'b0;
        prog_all  = 1'b0;
        prog_addr = addr_full;
        prog_data = '1;
        rd_start  = 1'b0;

        if (q.st == ST_BUSY) begin
            if (q.bcnt == '0) begin
                d.st   = ST_IDLE;
                d.dout = 1'b1;
            end else begin
                d.bcnt = q.bcnt - 1'b1;
                d.dout = ~cs;
            end
        end else if (!cs) begin
            d.st   = ST_IDLE;
            d.cnt  = '0;
            d.dout = 1'b1;
        end else if (sk_rise) begin
            unique case (q.st)
                ST_IDLE: begin
                    if (di) begin
                        d.st  = ST_OPC;
                        d.cnt = '0;
                    end
                end
                ST_OPC: begin
                    d.opc = {q.opc[0], di};
                    if (q.cnt == CW'(1)) begin
                        d.st  = ST_ADDR;
                        d.cnt = '0;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                ST_ADDR: begin
                    d.addr = addr_full;
                    if (q.cnt == ADDR_LAST) begin
                        d.cnt = '0;
                        unique case (op_e'(q.opc))
                            OP_READ: begin
                                rd_start = 1'b1;
                                d.sh     = rd_data;
                                d.dout   = 1'b0;      // leading dummy zero
                                d.st     = ST_RDOUT;
                            end
                            OP_WRITE: d.st = ST_DATA;
                            OP_ERASE: prog_req = 1'b1;
                            OP_EXT: begin
                                unique case (sub_e'(sub))
                                    SUB_WEN: begin
                                        d.wel = 1'b1;
                                        d.st  = ST_HOLD;
                                    end
                                    SUB_WDIS: begin
                                        d.wel = 1'b0;
                                        d.st  = ST_HOLD;
                                    end
                                    SUB_ERALL: begin
                                        prog_req = 1'b1;
                                        prog_all = 1'b1;
                                    end
                                    SUB_WRALL: d.st = ST_DATA;
                                    default:   d.st = ST_HOLD;
                                endcase
                            end
                            default: d.st = ST_HOLD;
                        endcase
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                ST_DATA: begin
                    d.sh = data_full;
                    if (q.cnt == WORD_LAST) begin
                        prog_req  = 1'b1;
                        prog_all  = (q.opc == OP_EXT);
                        prog_addr = q.addr;
                        prog_data = data_full;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                ST_RDOUT: begin
                    d.dout = q.sh[WORD_W-1];
                    d.sh   = {q.sh[WORD_W-2:0], 1'b0};
                    if (q.cnt == WORD_LAST) begin
                        d.st = ST_HOLD;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                ST_HOLD: d.dout = 1'b1;
                default: d.st = ST_IDLE;
            endcase
        end

        wr_en   = prog_req && q.wel && !prog_all;
        wr_all  = prog_req && q.wel && prog_all;
        wr_addr = prog_addr;
        wr_data = prog_data;

        if (prog_req) begin
            if (q.wel) begin
                d.st   = ST_BUSY;
                d.bcnt = BUSY_LOAD;
                d.dout = 1'b0;
            end else begin
                d.st = ST_HOLD;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.dout <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign rd_addr = addr_full;
    assign dout    = q.dout;
    assign busy    = (q.st == ST_BUSY);
    assign wel     = q.wel;

endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom
    import mw_eeprom_pkg::*;
#(
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned BUSY_CYCLES = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic sk,
    input  logic di,
    output logic dout
);

    logic              sk_rise_w;
    logic [ADDR_W-1:0] rd_addr_w;
    logic [WORD_W-1:0] rd_data_w;
    logic              wr_en_w;
    logic              wr_all_w;
    logic [ADDR_W-1:0] wr_addr_w;
    logic [WORD_W-1:0] wr_data_w;
    logic              busy_w;
    logic              wel_w;
    logic              rd_start_w;

    mw_eeprom_sk_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .sk      (sk),
        .sk_rise (sk_rise_w)
    );

    mw_eeprom_ctrl #(
        .ADDR_W      (ADDR_W),
        .BUSY_CYCLES (BUSY_CYCLES)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs       (cs),
        .sk_rise  (sk_rise_w),
        .di       (di),
        .rd_data  (rd_data_w),
        .rd_addr  (rd_addr_w),
        .wr_en    (wr_en_w),
        .wr_all   (wr_all_w),
        .wr_addr  (wr_addr_w),
        .wr_data  (wr_data_w),
        .dout     (dout),
        .busy     (busy_w),
        .wel      (wel_w),
        .rd_start (rd_start_w)
    );

    mw_eeprom_store #(
        .ADDR_W (ADDR_W),
        .DATA_W (WORD_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en_w),
        .wr_all  (wr_all_w),
        .wr_addr (wr_addr_w),
        .wr_data (wr_data_w),
        .rd_addr (rd_addr_w),
        .rd_data (rd_data_w)
    );

endmodule

// File: rtl/mw_eeprom_chk.sv
module mw_eeprom_chk #(
    parameter int unsigned BUSY_CYCLES = 40
) (
    input logic clk,
    input logic rst_n,
    input logic cs,
    input logic dout,
    input logic busy,
    input logic wel,
    input logic wr_en,
    input logic wr_all,
    input logic rd_start
);

    int unsigned run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= 0;
        end else begin
            run_q <= busy ? run_q + 1 : 0;
        end
    end

    AST_PROG_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en || wr_all) |-> wel);                                   // R5
    AST_PROG_THEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en || wr_all) |=> busy);                                  // R9
    AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_q < BUSY_CYCLES));                              // R9
    AST_BUSY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(run_q) == BUSY_CYCLES - 1));           // R9
    AST_BUSY_DOUT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && $past(cs)) |-> !dout);                // R9
    AST_IDLE_DOUT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !cs) |=> dout);                                     // R10
    AST_READ_DUMMY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_start |=> !dout);                                          // R3

endmodule

bind mw_eeprom mw_eeprom_chk #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs       (cs),
    .dout     (dout),
    .busy     (busy_w),
    .wel      (wel_w),
    .wr_en    (wr_en_w),
    .wr_all   (wr_all_w),
    .rd_start (rd_start_w)
);

// File: tb/mw_eeprom_bench.sv
module mw_eeprom_bench;

    localparam int AW   = 8;
    localparam int BUSY = 300;
    localparam int NW   = 1 << AW;

    logic clk = 1'b0;
    logic rst_n, cs, sk, di;
    logic dout;

    always #10 clk = ~clk;   // 50 MHz

    mw_eeprom #(.ADDR_W(AW), .BUSY_CYCLES(BUSY)) u_mw_eeprom (
        .clk   (clk),
        .rst_n (rst_n),
        .cs    (cs),
        .sk    (sk),
        .di    (di),
        .dout  (dout)
    );

    int n_vec  = 0;
    int n_bad  = 0;
    bit done   = 1'b0;

    logic [15:0] model [NW];
    logic        m_wel;

    logic [16:0] exp_q [$];
    logic [16:0] act_q [$];
    string       tag_q [$];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: compares read results as the driver produces them
    initial begin
        forever begin
            @(negedge clk);
            while (act_q.size() > 0 && exp_q.size() > 0) begin
                logic [16:0] a, e;
                string t;
                a = act_q.pop_front();
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(t, 32'(a), 32'(e));
            end
        end
    end

    task automatic bit_io(input logic b, output logic o);
        @(negedge clk);
        sk = 1'b0;
        di = b;
        repeat (2) @(negedge clk);
        sk = 1'b1;
        repeat (2) @(negedge clk);
        o = dout;
    endtask

    task automatic frame_begin();
        @(negedge clk);
        cs = 1'b1;
        sk = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic frame_end();
        @(negedge clk);
        sk = 1'b0;
        cs = 1'b0;
        di = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic send_head(input logic [1:0] op, input logic [AW-1:0] a, output logic o);
        bit_io(1'b1, o);
        bit_io(op[1], o);
        bit_io(op[0], o);
        for (int i = AW - 1; i >= 0; i--) bit_io(a[i], o);
    endtask

    task automatic send_word(input logic [15:0] w, output logic o);
        for (int i = 15; i >= 0; i--) bit_io(w[i], o);
    endtask

    task automatic do_read(input logic [AW-1:0] a, input int lead, input string tag);
        logic o;
        logic [16:0] got;
        frame_begin();
        for (int i = 0; i < lead; i++) bit_io(1'b0, o);
        send_head(2'b10, a, o);
        got = {16'h0, o};
        for (int i = 0; i < 16; i++) begin
            bit_io(1'b0, o);
            got = {got[15:0], o};
        end
        exp_q.push_back({1'b0, model[a]});
        act_q.push_back(got);
        tag_q.push_back(tag);
        bit_io(1'b0, o);
        chk("R3 output high after last bit", 32'(o), 32'd1);
        frame_end();
    endtask

    task automatic finish_prog(input logic o, input string tag, input bit accepted);
        chk(accepted ? {tag, " R9 busy at frame end"} : {tag, " R5 no busy"},
            32'(o), accepted ? 32'd0 : 32'd1);
        frame_end();
        if (accepted) repeat (BUSY + 4) @(negedge clk);
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [15:0] w, input string tag);
        logic o;
        bit acc;
        acc = m_wel;
        frame_begin();
        send_head(2'b01, a, o);
        send_word(w, o);
        if (acc) model[a] = w;
        finish_prog(o, tag, acc);
    endtask

    task automatic do_erase(input logic [AW-1:0] a, input string tag);
        logic o;
        bit acc;
        acc = m_wel;
        frame_begin();
        send_head(2'b11, a, o);
        if (acc) model[a] = 16'hFFFF;
        finish_prog(o, tag, acc);
    endtask

    // extended opcode 00: sub in top two address bits, low bits don't care
    task automatic do_ext(input logic [1:0] sub, input logic [AW-3:0] low,
                          input logic [15:0] w, input string tag);
        logic o;
        bit acc;
        acc = 1'b0;
        frame_begin();
        send_head(2'b00, {sub, low}, o);
        case (sub)
            2'b11: begin m_wel = 1'b1; chk({tag, " R8 no busy"}, 32'(o), 32'd1); frame_end(); end
            2'b00: begin m_wel = 1'b0; chk({tag, " R8 no busy"}, 32'(o), 32'd1); frame_end(); end
            2'b10: begin
                acc = m_wel;
                if (acc) for (int i = 0; i < NW; i++) model[i] = 16'hFFFF;
                finish_prog(o, tag, acc);
            end
            default: begin
                send_word(w, o);
                acc = m_wel;
                if (acc) for (int i = 0; i < NW; i++) model[i] = w;
                finish_prog(o, tag, acc);
            end
        endcase
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic o;
        cs = 1'b0; sk = 1'b0; di = 1'b0; rst_n = 1'b0;
        for (int i = 0; i < NW; i++) model[i] = 16'hFFFF;
        m_wel = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 output high after reset", 32'(dout), 32'd1);

        do_read(8'h05, 0, "R1 word erased after reset");
        do_write(8'h05, 16'h1234, "R5 write with latch clear");
        do_read(8'h05, 0, "R5 word unchanged");

        do_ext(2'b11, 6'h2A, 16'h0, "R11 enable with junk low bits");
        do_write(8'h05, 16'h1234, "R4 write");
        do_read(8'h05, 0, "R4 read back");
        do_write(8'hFE, 16'hA5C3, "R4 write high address");
        do_read(8'hFE, 0, "R11 msb-first address");
        do_read(8'h7F, 0, "R11 bit-reversed address untouched");

        do_read(8'h05, 3, "R2 leading zeros skipped");

        // R10: abort a write in its data phase
        frame_begin();
        send_head(2'b01, 8'h10, o);
        for (int i = 0; i < 8; i++) bit_io(1'b1, o);
        frame_end();
        chk("R10 output high after abort", 32'(dout), 32'd1);
        do_read(8'h10, 0, "R10 aborted write left word");
        // R10: abort a read mid-data
        frame_begin();
        send_head(2'b10, 8'h05, o);
        for (int i = 0; i < 4; i++) bit_io(1'b0, o);
        frame_end();
        chk("R10 output high after read abort", 32'(dout), 32'd1);

        // R9: busy behaviour and ignored command
        frame_begin();
        send_head(2'b01, 8'h20, o);
        send_word(16'h5555, o);
        model[8'h20] = 16'h5555;
        chk("R9 busy at frame end", 32'(o), 32'd0);
        repeat (3) @(negedge clk);
        chk("R9 output low while busy", 32'(dout), 32'd0);
        frame_end();
        frame_begin();
        send_head(2'b11, 8'h05, o);
        frame_end();
        repeat (BUSY) @(negedge clk);
        cs = 1'b1;
        repeat (3) @(negedge clk);
        chk("R9 ready after busy", 32'(dout), 32'd1);
        cs = 1'b0;
        repeat (3) @(negedge clk);
        do_read(8'h05, 0, "R9 erase during busy ignored");
        do_read(8'h20, 0, "R9 write completed");

        do_erase(8'hFE, "R6 erase");
        do_read(8'hFE, 0, "R6 erased word");
        do_read(8'h05, 0, "R6 neighbour kept");

        do_ext(2'b01, 6'h15, 16'hBEEF, "R7 write all");
        do_read(8'h00, 0, "R7 write all low");
        do_read(8'h80, 0, "R7 write all mid");
        do_read(8'hFF, 0, "R7 write all top");
        do_ext(2'b10, 6'h00, 16'h0, "R7 erase all");
        do_read(8'h00, 0, "R7 erase all low");
        do_read(8'h20, 0, "R7 erase all mid");

        do_ext(2'b00, 6'h3F, 16'h0, "R8 disable");
        do_write(8'h33, 16'h0F0F, "R8 write after disable");
        do_read(8'h33, 0, "R8 disabled write no effect");
        do_ext(2'b10, 6'h00, 16'h0, "R8 erase all after disable");

        repeat (4) @(negedge clk);
        chk("R3 scoreboard drained", 32'(act_q.size()), 32'd0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule